// File: doc/BRIEF.md
# Dual Tapped Serial Delay Line

The block holds two independent serial shift chains, section A and section B. Each chain is 64 single-bit stages long. Each section has its own clock, its own serial data input and its own write enable. While the write enable is low, a section moves its contents one stage along on every rising edge of its clock. While the write enable is high, the section freezes.

Every section brings out four taps, one after each quarter of its length. A user can therefore pick a 16-, 32-, 48- or 64-cycle delay of the serial stream. Longer delays come from wiring section A's last tap to section B's data input and running both sections from one clock. The two sections then form a single chain of 80, 96, 112 or 128 stages, read from section B's taps.

A shared asynchronous active-low reset clears both chains.

Top module: `dual_tap_delay`

## Requirements
- R1: A section is a chain of 64 stages. On a rising clock edge with shifting enabled, each stage from 2 to 64 takes the value the previous stage held before that edge.
- R2: On a rising edge of its clock with its write enable low, stage 1 of a section captures that section's data input.
- R3: Tap output bit 0 shows stage 16, bit 1 shows stage 32, bit 2 shows stage 48 and bit 3 shows stage 64. After the edge that captures a bit into stage 1, that bit appears on the stage-16 tap 15 shifting edges later, and on the stage-64 tap 63 shifting edges later. This is a delay of 16 or 64 clocks from input to tap.
- R4: While a section's write enable is high, its rising clock edges leave every stage unchanged, and its data input has no effect.
- R5: The two sections are independent. Clock edges, data and write enable of one section never change the taps of the other.
- R6: Driving reset low clears every stage of both sections to 0 at once, without waiting for a clock edge.
- R7: With section B's data input driven from section A's stage-64 tap and both sections on one clock, section B's tap bits 0 to 3 give the input of section A delayed by 80, 96, 112 and 128 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Section A shift clock, rising edge |
| clkB | input | 1 | Section B shift clock, rising edge |
| rstN | input | 1 | Asynchronous active-low clear of both sections |
| dinA | input | 1 | Section A serial data input |
| dinB | input | 1 | Section B serial data input |
| wrEnA | input | 1 | Section A freeze control, low = shift, high = hold |
| wrEnB | input | 1 | Section B freeze control, low = shift, high = hold |
| tapA | output | 4 | Section A taps after stages 16, 32, 48, 64 (bit 0 to 3) |
| tapB | output | 4 | Section B taps after stages 16, 32, 48, 64 (bit 0 to 3) |

## Verification
A bit driven before a rising edge sits in stage 1 right after that edge. It reaches tap k after k-1 further shifting edges. Held edges add nothing to that count. Each bench step sets the inputs on a falling edge, lets exactly one rising edge pass, updates a reference history from the values that edge captured, and compares all eight taps on the next falling edge. In cascade mode section B's reference takes section A's stage-64 value from before the shared edge. The reset check compares the taps while reset is still low, before any clock edge follows.

// File: rtl/dual_tap_delay_pkg.sv
package dual_tap_delay_pkg;
  typedef struct packed {
    logic shift;
    logic hold;
  } sectStrobe_t;
endpackage

// File: rtl/section_ctrl.sv
module section_ctrl
  import dual_tap_delay_pkg::*;
(
  input  logic        wrEn,
  output sectStrobe_t strobes
);
  always_comb begin
    strobes.shift = ~wrEn;
    strobes.hold  = wrEn;
  end
endmodule

// File: rtl/section_datapath.sv
module section_datapath
  import dual_tap_delay_pkg::*;
#(
  parameter int STAGES    = 64,
  parameter int TAP_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 din,
  input  sectStrobe_t          strobes,
  output logic [TAP_COUNT-1:0] taps
);
  localparam int SEG_LEN = STAGES / TAP_COUNT;

  logic [STAGES-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else if (strobes.shift) begin
      stageQ <= {stageQ[STAGES-2:0], din};
    end
  end

  for (genvar t = 0; t < TAP_COUNT; t++) begin : gTap
    assign taps[t] = stageQ[SEG_LEN*(t+1)-1];
  end

  // R2: stage 1 takes the data input on a shifting edge
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> stageQ[0] == $past(din));

  // R4: a held edge changes nothing
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> $stable(stageQ));

  // R6: the first edge after reset release sees a cleared chain
  a_r6_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> stageQ == '0);

  for (genvar i = 1; i < STAGES; i++) begin : gChainChk
    // R1: each stage takes its predecessor's value
    a_r1_advance: assert property (@(posedge clk) disable iff (!rstN)
      strobes.shift |=> stageQ[i] == $past(stageQ[i-1]));
  end
endmodule

// File: rtl/dual_tap_delay.sv
module dual_tap_delay
  import dual_tap_delay_pkg::*;
#(
  parameter int STAGES    = 64,
  parameter int TAP_COUNT = 4
) (
  input  logic                 clkA,
  input  logic                 clkB,
  input  logic                 rstN,
  input  logic                 dinA,
  input  logic                 dinB,
  input  logic                 wrEnA,
  input  logic                 wrEnB,
  output logic [TAP_COUNT-1:0] tapA,
  output logic [TAP_COUNT-1:0] tapB
);
  localparam int SECTIONS = 2;

  logic [SECTIONS-1:0]           clkVec, dinVec, wrEnVec;
  logic [SECTIONS-1:0][TAP_COUNT-1:0] tapVec;

  assign clkVec  = {clkB, clkA};
  assign dinVec  = {dinB, dinA};
  assign wrEnVec = {wrEnB, wrEnA};

  for (genvar s = 0; s < SECTIONS; s++) begin : gSect
    sectStrobe_t strobes;

    section_ctrl uCtrl (
      .wrEn   (wrEnVec[s]),
      .strobes(strobes)
    );

    section_datapath #(
      .STAGES   (STAGES),
      .TAP_COUNT(TAP_COUNT)
    ) uPath (
      .clk    (clkVec[s]),
      .rstN   (rstN),
      .din    (dinVec[s]),
      .strobes(strobes),
      .taps   (tapVec[s])
    );
  end

  assign tapA = tapVec[0];
  assign tapB = tapVec[1];
endmodule

// File: tb/tb_dual_tap_delay.sv
module tb_dual_tap_delay;
  localparam int CLK_PERIOD = 10;

  logic clkA = 1'b0;
  logic clkBEn = 1'b0;
  logic clkB;
  logic rstN = 1'b0;
  logic dinA = 1'b0, dinBReg = 1'b0, wrEnA = 1'b1, wrEnB = 1'b1;
  logic cascadeOn = 1'b0;
  logic dinB;
  logic [3:0] tapA, tapB;

  logic [63:0] refA = '0, refB = '0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clkA = ~clkA;
  assign clkB = clkA & clkBEn;
  assign dinB = cascadeOn ? tapA[3] : dinBReg;

  dual_tap_delay dut (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .dinA(dinA), .dinB(dinB), .wrEnA(wrEnA), .wrEnB(wrEnB),
    .tapA(tapA), .tapB(tapB)
  );

  function automatic logic [3:0] expTaps(logic [63:0] h);
    return {h[63], h[47], h[31], h[15]};
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: taps actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one rising edge; entered and left at a falling edge
  task automatic step(logic dA, logic weA, logic dB, logic weB, logic runB,
                      string reqA, string reqB);
    logic feedB;
    dinA = dA; wrEnA = weA; dinBReg = dB; wrEnB = weB; clkBEn = runB;
    @(posedge clkA);
    feedB = cascadeOn ? refA[63] : dB;
    if (!weA) refA = {refA[62:0], dA};
    if (runB && !weB) refB = {refB[62:0], feedB};
    @(negedge clkA);
    chk(reqA, tapA, expTaps(refA));
    chk(reqB, tapB, expTaps(refB));
  endtask

  task automatic testReset();
    rstN = 1'b0;
    #1;
    chk("R6 reset A", tapA, 4'b0);
    chk("R6 reset B", tapB, 4'b0);
    refA = '0; refB = '0;
    @(negedge clkA);
    rstN = 1'b1;
  endtask

  task automatic testStreamA();
    for (int i = 0; i < 150; i++)
      step(1'($urandom), 1'b0, 1'b0, 1'b1, 1'b0, "R1 R2 R3 stream A", "R5 B idle");
  endtask

  task automatic testHoldA();
    for (int i = 0; i < 12; i++)
      step(1'($urandom), 1'b1, 1'b0, 1'b1, 1'b0, "R4 hold A", "R5 B idle");
  endtask

  task automatic testOnlyB();
    for (int i = 0; i < 80; i++)
      step(1'($urandom), 1'b1, 1'($urandom), 1'b0, 1'b1, "R5 A frozen", "R3 stream B");
    for (int i = 0; i < 10; i++)
      step(1'($urandom), 1'b0, 1'($urandom), 1'b1, 1'b1, "R5 A shifts", "R4 hold B");
  endtask

  task automatic testPattern();
    // a single one walking through A
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R3 walking one", "R5 B idle");
    for (int i = 0; i < 70; i++)
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 walking one", "R5 B idle");
  endtask

  task automatic testCascade();
    cascadeOn = 1'b1;
    for (int i = 0; i < 200; i++)
      step(1'($urandom), 1'b0, 1'b0, 1'b0, 1'b1, "R7 cascade A", "R7 cascade B");
    cascadeOn = 1'b0;
  endtask

  task automatic testMidReset();
    #1;
    rstN = 1'b0;
    #1;
    chk("R6 async clear A", tapA, 4'b0);
    chk("R6 async clear B", tapB, 4'b0);
    refA = '0; refB = '0;
    @(negedge clkA);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++)
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 after clear A", "R6 after clear B");
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clkA);
    testReset();
    testStreamA();
    testHoldA();
    testOnlyB();
    testPattern();
    testCascade();
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule